// File: doc/BRIEF.md
# Carry-Chain Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit of parameterised width, four bits by default. It takes two operands, a three-bit function select and a carry input. It returns a result word and a carry output. The top select bit picks the mode. When it is 0, the low two bits pick what the second input of a ripple chain of full adders receives: zero, the B operand, the inverted B operand, or all ones. The carry input then completes increment, add, subtract and decrement. When the top select bit is 1, the same full adders produce bitwise logic results because every carry between stages is held at zero.

The unit sits between operand sources and a destination register in a datapath. All outputs follow the inputs without any clock, so the select and carry encoding below is the whole control interface.

Top module: `sel_carry_alu`

## Requirements
- R1: With select 3'b000 the result is A when the carry input is 0, and A+1 (modulo 2^WIDTH) when it is 1.
- R2: With select 3'b001 the result is A+B when the carry input is 0, and A+B+1 when it is 1.
- R3: With select 3'b010 the result is A+~B, which equals A-B-1 when the carry input is 0, and A-B in two's complement when it is 1.
- R4: With select 3'b011 the result is A-1 when the carry input is 0, and A when it is 1.
- R5: With select 3'b100 the result is A OR B.
- R6: With select 3'b101 the result is A XOR B.
- R7: With select 3'b110 the result is A AND B.
- R8: With select 3'b111 the result is the bitwise complement of A.
- R9: When select bit 2 is 1, the carry input has no effect on the result.
- R10: When select bit 2 is 1, the carry output is 0.
- R11: When select bit 2 is 0, the carry output is the carry out of the most significant adder stage, that is bit WIDTH of A + Y + carry-in with Y chosen as in R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sel_i | input | 3 | Function select; bit 2 chooses logic (1) or arithmetic (0) |
| cin_i | input | 1 | Carry into the least significant stage |
| f_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the most significant stage, 0 in logic mode |

## Verification
All sixteen combinations of select and carry input are driven with random operands. This shows that each arithmetic Y choice and each logic function is wired to its own code. Directed operands cover the wrap points: all ones plus one, zero minus one, and equal operands under subtraction. These separate a correct top-stage carry from a missing or inverted one. In logic mode each operand pair is applied with both carry values, so a carry that leaks between stages shows up as a difference in the result or as a nonzero carry output.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // Function select layout: bit 2 chooses the mode, bits 1:0 the variant.
  typedef enum logic [1:0] {
    YSEL_ZERO = 2'b00,
    YSEL_B    = 2'b01,
    YSEL_NOTB = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    LOP_OR   = 2'b00,
    LOP_XOR  = 2'b01,
    LOP_AND  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;

  localparam int SEL_W = 3;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o
);
  logic       logic_mode;
  logic [1:0] variant;

  assign logic_mode = sel_i[2];
  assign variant    = sel_i[1:0];

  // Full-adder X and Y inputs; in logic mode the sum bit X^Y forms the result.
  always_comb begin
    x_o = a_i;
    y_o = '0;
    if (!logic_mode) begin
      unique case (ysel_e'(variant))
        YSEL_ZERO: y_o = '0;
        YSEL_B:    y_o = b_i;
        YSEL_NOTB: y_o = ~b_i;
        YSEL_ONES: y_o = '1;
      endcase
    end else begin
      unique case (lop_e'(variant))
        LOP_OR:   begin x_o = a_i | b_i; y_o = '0;  end
        LOP_XOR:  begin x_o = a_i;       y_o = b_i; end
        LOP_AND:  begin x_o = a_i & b_i; y_o = '0;  end
        LOP_NOTA: begin x_o = a_i;       y_o = '1;  end
      endcase
    end
  end
endmodule

// File: rtl/alu_adder_chain.sv
module alu_adder_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  input  logic             kill_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin_i & ~kill_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic prop;
    logic gen;
    assign prop         = x_i[i] ^ y_i[i];
    assign gen          = x_i[i] & y_i[i];
    assign sum_o[i]     = prop ^ carry[i];
    assign carry[i+1]   = (gen | (prop & carry[i])) & ~kill_i;
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/sel_carry_alu.sv
module sel_carry_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] x_op;
  logic [WIDTH-1:0] y_op;

  alu_operand_sel #(.WIDTH(WIDTH)) u_opsel (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .x_o   (x_op),
    .y_o   (y_op)
  );

  alu_adder_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i    (x_op),
    .y_i    (y_op),
    .cin_i  (cin_i),
    .kill_i (sel_i[2]),
    .sum_o  (f_o),
    .cout_o (cout_o)
  );
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       sel_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] f_o,
  input logic             cout_o
);
  always_comb begin
    AST_LOGIC_NO_CARRY: assert (!(sel_i[2] && cout_o)); // R10
    AST_PASS_A: assert (!(sel_i == 3'b000 && !cin_i) || (f_o == a_i && !cout_o)); // R1
    AST_DEC_PASS: assert (!(sel_i == 3'b011 && cin_i) || (f_o == a_i && cout_o)); // R4
    AST_NOT_A: assert (!(sel_i == 3'b111) || (f_o == ~a_i)); // R8
    AST_INC_WRAP: assert (!(sel_i == 3'b000 && cin_i && a_i == '1) || (f_o == '0 && cout_o)); // R11
    AST_SUB_SELF: assert (!(sel_i == 3'b010 && cin_i && a_i == b_i) || (f_o == '0 && cout_o)); // R3
  end
endmodule

bind sel_carry_alu alu_checker #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .sel_i  (sel_i),
  .cin_i  (cin_i),
  .f_o    (f_o),
  .cout_o (cout_o)
);

// File: tb/sel_carry_alu_test.sv
module sel_carry_alu_test;
  localparam int W = 4;
  localparam int MAXC = 100000;

  logic         clk;
  logic [W-1:0] a, b, f;
  logic [2:0]   sel;
  logic         cin, cout;
  int           n_chk, n_bad, cycles;
  logic         done;

  sel_carry_alu #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin), .f_o(f), .cout_o(cout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W:0] model(input logic [W-1:0] ma, input logic [W-1:0] mb,
                                       input logic [2:0] ms, input logic mc);
    logic [W:0] ea, eb, ec;
    ea = {1'b0, ma};
    eb = {1'b0, mb};
    ec = {{W{1'b0}}, mc};
    case (ms)
      3'b000: return ea + ec;
      3'b001: return ea + eb + ec;
      3'b010: return ea + {1'b0, ~mb} + ec;
      3'b011: return ea + {1'b0, {W{1'b1}}} + ec;
      3'b100: return {1'b0, ma | mb};
      3'b101: return {1'b0, ma ^ mb};
      3'b110: return {1'b0, ma & mb};
      default: return {1'b0, ~ma};
    endcase
  endfunction

  function automatic string tag(input logic [2:0] ms);
    case (ms)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb,
                       input logic [2:0] ts, input logic tc);
    logic [W:0] exp;
    @(posedge clk);
    a = ta; b = tb; sel = ts; cin = tc;
    @(negedge clk);
    exp = model(ta, tb, ts, tc);
    n_chk++;
    if (f !== exp[W-1:0]) begin
      n_bad++;
      $display("FAIL %s result a=%h b=%h sel=%b cin=%b actual=%h expected=%h",
               tag(ts), ta, tb, ts, tc, f, exp[W-1:0]);
    end
    n_chk++;
    if (cout !== exp[W]) begin
      n_bad++;
      $display("FAIL %s carry a=%h b=%h sel=%b cin=%b actual=%b expected=%b",
               ts[2] ? "R10" : "R11", ta, tb, ts, tc, cout, exp[W]);
    end
  endtask

  // R9: logic result identical for both carry inputs
  task automatic cin_ignored(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic [1:0] v);
    logic [W-1:0] f0;
    apply(ta, tb, {1'b1, v}, 1'b0);
    f0 = f;
    apply(ta, tb, {1'b1, v}, 1'b1);
    n_chk++;
    if (f !== f0) begin
      n_bad++;
      $display("FAIL R9 a=%h b=%h sel=1%b actual=%h expected=%h", ta, tb, v, f, f0);
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAXC && !done) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, MAXC);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int unused_seed;
    done = 1'b0;
    n_chk = 0; n_bad = 0;
    a = '0; b = '0; sel = '0; cin = 1'b0;
    unused_seed = $urandom(32'h5EED_0A1B);
    // idle vector: all-zero inputs give zero result and carry (R1)
    apply('0, '0, 3'b000, 1'b0);
    // directed corners
    apply('1, '0, 3'b000, 1'b1);          // R1 wrap, R11 carry
    apply('1, 4'h1, 3'b001, 1'b0);        // R2 overflow
    apply('1, '1, 3'b001, 1'b1);          // R2 max with carry
    apply(4'h6, 4'h6, 3'b010, 1'b1);      // R3 equal operands
    apply(4'h3, 4'h7, 3'b010, 1'b1);      // R3 borrow
    apply(4'h9, 4'h2, 3'b010, 1'b0);      // R3 minus one
    apply('0, 4'h5, 3'b011, 1'b0);        // R4 zero minus one
    apply(4'hA, 4'h5, 3'b011, 1'b1);      // R4 transfer
    apply(4'hC, 4'hA, 3'b100, 1'b1);      // R5
    apply(4'hC, 4'hA, 3'b101, 1'b1);      // R6
    apply(4'hC, 4'hA, 3'b110, 1'b1);      // R7
    apply(4'h5, 4'hF, 3'b111, 1'b1);      // R8
    for (int v = 0; v < 4; v++) cin_ignored('1, '1, v[1:0]);
    // random sweep across every select and carry combination
    for (int r = 0; r < 256; r++) begin
      for (int k = 0; k < 16; k++) begin
        apply(W'($urandom), W'($urandom), k[3:1], k[0]);
      end
    end
    for (int r = 0; r < 32; r++) cin_ignored(W'($urandom), W'($urandom), 2'(r));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule